// File: doc/BRIEF.md
# Initiator Controller Register Front-End

This block is the byte-wide register side of a simple bus-initiator controller for a SCSI-style disk bus. A host reaches sixteen byte registers placed four bytes apart. One slot is a byte FIFO port, one is a command register, and three read-only slots report bus phase, interrupt reason and sequence step. Every other slot either echoes what was written or keeps the value only on the write side, where it feeds the transfer length and the target number.

A write to the command slot is decoded in the same cycle. The effects are committed at the clock edge: register updates, FIFO emptying, a register-image reset, and a level interrupt request that stays high until the host pulses a clear input. Wire signalling on the bus, the targets themselves and memory transfers are outside this block. A presence vector stands in for the targets.

Top module: `sif_reg_front`

## Requirements
- R1: The slot is bus_addr[5:2], and bus_addr[1:0] is ignored. Writes to slots 0, 1, 3, 8 and 11–15 read back the written byte. Writes to slots 4–7, 9 and 10 leave the read image unchanged. xfer_len is {last write to slot 1, last write to slot 0}.
- R2: After reset every slot reads 0x00 except slot 14, which reads CHIP_REV (default 0x04). irq and fifo_ovf are low.
- R3: A write to slot 2 appends a byte to the FIFO. A read of slot 2 while the FIFO holds data returns the oldest byte in that cycle, removes it and raises irq. Slot 2 then keeps that byte.
- R4: A read of slot 2 while the FIFO is empty returns the last removed byte. It does not raise irq.
- R5: When the FIFO count reaches zero, both pointers return to zero. A later write followed by a read returns the new byte.
- R6: A write to a full FIFO (FIFO_DEPTH bytes) is dropped and sets the sticky fifo_ovf. Only a FIFO-emptying command or reset clears fifo_ovf.
- R7: Command opcode 0x01 (command byte bits 6:0) empties the FIFO and clears fifo_ovf. It sets slot 5 (interrupt reason) to 0x08 and slot 6 (sequence step) to 0x00, and it does not raise irq.
- R8: Opcode 0x02 returns the whole read image, slot 3 included, to its reset values. FIFO contents and irq are kept.
- R9: Opcodes 0x42 and 0x43 select the target number held in bits 2:0 of the last write to slot 4. If that number is at least NUM_TGT, or its tgt_present bit is low, the block sets slot 4 (status) to 0x80, slot 5 to 0x20 and slot 6 to 0x00, raises irq and empties the FIFO.
- R10: A select of a present target sets slot 4 to 0x91, slot 5 to 0x18 and slot 6 to 0x04, raises irq and empties the FIFO.
- R11: Opcode 0x10 with command bit 7 set (DMA) sets slot 4 to 0x93, slot 5 to 0x10 and slot 6 to 0x00, and raises irq. With bit 7 clear it only raises irq.
- R12: Opcode 0x12 sets slot 5 to 0x20 and slot 6 to 0x00 and raises irq. Opcodes 0x00, 0x03, 0x1A and all undefined opcodes change nothing but slot 3 and do not raise irq.
- R13: irq is a level that holds until irq_clr is high at a clock edge. A raising event in the same cycle wins over the clear.
- R14: When bus_wr and bus_rd are both high, only the write takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 6 | Byte address; bits 5:2 pick the slot |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe; a read of slot 2 removes a byte |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed slot, combinational |
| tgt_present | input | NUM_TGT | One bit per target number, high if the target answers |
| irq_clr | input | 1 | Clears the interrupt request |
| irq | output | 1 | Level interrupt request |
| fifo_ovf | output | 1 | Sticky flag: a FIFO write was dropped |
| xfer_len | output | 16 | Programmed transfer length |

## Verification
The bench targets the FIFO edges:
- Reading an empty FIFO must neither move data nor raise irq. A design that pops regardless returns stale memory and interrupts falsely.
- Filling the FIFO one byte past full must keep the first FIFO_DEPTH bytes in order. A design that wraps instead overwrites the oldest byte.
- After the FIFO drains, the next byte written must be the next byte read.

It also checks that a select empties the FIFO, by reading back the byte removed before it rather than the pending one. It drives both select failure modes, an absent target and a number beyond NUM_TGT, since a design that indexes the presence vector without a range check accepts the second. It pulses clear in the same cycle as a pop to catch a design whose clear wins, and issues a simultaneous read and write to catch a design that pops during a push.

// File: rtl/sif_pkg.sv
package sif_pkg;

   localparam int NSLOT = 16;

   localparam logic [3:0] SL_LEN_LO = 4'd0;
   localparam logic [3:0] SL_LEN_HI = 4'd1;
   localparam logic [3:0] SL_FIFO   = 4'd2;
   localparam logic [3:0] SL_CMD    = 4'd3;
   localparam logic [3:0] SL_STAT   = 4'd4;   // read side: status, write side: target
   localparam logic [3:0] SL_RSN    = 4'd5;
   localparam logic [3:0] SL_STEP   = 4'd6;
   localparam logic [3:0] SL_REV    = 4'd14;

   // status fields
   localparam logic [7:0] ST_PEND   = 8'h80;
   localparam logic [7:0] ST_TC     = 8'h10;
   localparam logic [7:0] PH_DIN    = 8'h01;
   localparam logic [7:0] PH_STATUS = 8'h03;

   // interrupt reasons
   localparam logic [7:0] RSN_DONE  = 8'h08;
   localparam logic [7:0] RSN_SVC   = 8'h10;
   localparam logic [7:0] RSN_DISC  = 8'h20;

   localparam logic [7:0] STEP_CMD  = 8'h04;

   localparam logic [6:0] OP_NOP    = 7'h00;
   localparam logic [6:0] OP_FLUSH  = 7'h01;
   localparam logic [6:0] OP_CHIP   = 7'h02;
   localparam logic [6:0] OP_BUSRST = 7'h03;
   localparam logic [6:0] OP_XFER   = 7'h10;
   localparam logic [6:0] OP_MSGOK  = 7'h12;
   localparam logic [6:0] OP_ATN    = 7'h1A;
   localparam logic [6:0] OP_SEL    = 7'h42;
   localparam logic [6:0] OP_SELSTP = 7'h43;

   typedef struct packed {
      logic       wr_stat;
      logic [7:0] stat;
      logic       wr_rsn;
      logic [7:0] rsn;
      logic       wr_step;
      logic [7:0] step;
      logic       fire;
      logic       flush;
      logic       chip_rst;
   } sif_effect_t;

   function automatic bit slot_echoes(int s);
      return (s == 0) || (s == 1) || (s == 3) || (s == 8) || (s >= 11 && s <= 15);
   endfunction

endpackage

// File: rtl/sif_byte_fifo.sv
module sif_byte_fifo #(
   parameter int DEPTH = 16,
   parameter int W     = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         push,
   input  logic         pop,
   input  logic [W-1:0] din,
   output logic [W-1:0] head,
   output logic         empty,
   output logic         full,
   output logic         ovf
);
   localparam int  AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int  CW   = AW + 1;
   localparam bit  POW2 = (DEPTH & (DEPTH - 1)) == 0;

   if (DEPTH < 2) begin : g_bad_depth
      $error("sif_byte_fifo: DEPTH must be at least 2");
   end
   if (W < 1) begin : g_bad_width
      $error("sif_byte_fifo: W must be at least 1");
   end

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wr_ptr, rd_ptr, wr_inc, rd_inc;
   logic [CW-1:0] cnt, cnt_n;
   logic          do_push, do_pop;

   if (POW2) begin : g_wrap_pow2
      assign wr_inc = wr_ptr + 1'b1;
      assign rd_inc = rd_ptr + 1'b1;
   end else begin : g_wrap_mod
      assign wr_inc = (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      assign rd_inc = (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
   end

   assign empty   = (cnt == '0);
   assign full    = (cnt == CW'(DEPTH));
   assign do_push = push & ~full;
   assign do_pop  = pop & ~empty;
   assign cnt_n   = cnt + CW'(do_push) - CW'(do_pop);
   assign head    = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (do_push && !clr) mem[wr_ptr] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt    <= '0;
         wr_ptr <= '0;
         rd_ptr <= '0;
         ovf    <= 1'b0;
      end else if (clr) begin
         cnt    <= '0;
         wr_ptr <= '0;
         rd_ptr <= '0;
         ovf    <= 1'b0;
      end else begin
         cnt <= cnt_n;
         if (push && full) ovf <= 1'b1;
         if (cnt_n == '0) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
         end else begin
            if (do_push) wr_ptr <= wr_inc;
            if (do_pop)  rd_ptr <= rd_inc;
         end
      end
   end

   // R5
   rewind_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt == '0) |-> (wr_ptr == '0 && rd_ptr == '0));

   // R6
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (push && full && !pop && !clr) |=> (full && ovf));

   // R6
   ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf && !clr) |=> ovf);

endmodule

// File: rtl/sif_cmd_decode.sv
module sif_cmd_decode
   import sif_pkg::*;
(
   input  logic        cmd_wr,
   input  logic [7:0]  cmd,
   input  logic        tgt_ok,
   output sif_effect_t eff
);
   logic       dma;
   logic [6:0] op;

   assign dma = cmd[7];
   assign op  = cmd[6:0];

   always_comb begin
      eff = '0;
      if (cmd_wr) begin
         case (op)
            OP_FLUSH: begin
               eff.flush   = 1'b1;
               eff.wr_rsn  = 1'b1;
               eff.rsn     = RSN_DONE;
               eff.wr_step = 1'b1;
               eff.step    = 8'h00;
            end
            OP_CHIP: eff.chip_rst = 1'b1;
            OP_XFER: begin
               eff.fire = 1'b1;
               if (dma) begin
                  eff.wr_stat = 1'b1;
                  eff.stat    = ST_PEND | ST_TC | PH_STATUS;
                  eff.wr_rsn  = 1'b1;
                  eff.rsn     = RSN_SVC;
                  eff.wr_step = 1'b1;
                  eff.step    = 8'h00;
               end
            end
            OP_MSGOK: begin
               eff.fire    = 1'b1;
               eff.wr_rsn  = 1'b1;
               eff.rsn     = RSN_DISC;
               eff.wr_step = 1'b1;
               eff.step    = 8'h00;
            end
            OP_SEL, OP_SELSTP: begin
               eff.fire    = 1'b1;
               eff.flush   = 1'b1;
               eff.wr_stat = 1'b1;
               eff.wr_rsn  = 1'b1;
               eff.wr_step = 1'b1;
               if (tgt_ok) begin
                  eff.stat = ST_PEND | ST_TC | PH_DIN;
                  eff.rsn  = RSN_SVC | RSN_DONE;
                  eff.step = STEP_CMD;
               end else begin
                  eff.stat = ST_PEND;
                  eff.rsn  = RSN_DISC;
                  eff.step = 8'h00;
               end
            end
            default: eff = '0;   // no-op, bus reset, attention, undefined
         endcase
      end
   end

endmodule

// File: rtl/sif_reg_front.sv
module sif_reg_front
   import sif_pkg::*;
#(
   parameter int         FIFO_DEPTH = 16,
   parameter int         NUM_TGT    = 5,
   parameter logic [7:0] CHIP_REV   = 8'h04
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [5:0]         bus_addr,
   input  logic               bus_wr,
   input  logic               bus_rd,
   input  logic [7:0]         bus_wdata,
   output logic [7:0]         bus_rdata,
   input  logic [NUM_TGT-1:0] tgt_present,
   input  logic               irq_clr,
   output logic               irq,
   output logic               fifo_ovf,
   output logic [15:0]        xfer_len
);
   if (NUM_TGT < 1 || NUM_TGT > 8) begin : g_bad_tgt
      $error("sif_reg_front: NUM_TGT must lie in 1..8");
   end
   if (FIFO_DEPTH < 2) begin : g_bad_fifo
      $error("sif_reg_front: FIFO_DEPTH must be at least 2");
   end

   logic [3:0]       slot;
   logic [NSLOT-1:0] wr_hit;
   logic             cmd_wr, push, pop_req, pop_ok;
   logic [7:0]       img [NSLOT];
   logic [7:0]       len_lo, len_hi, tgt_sel;
   logic [7:0]       pres8;
   logic             tgt_ok;
   logic [7:0]       fifo_head;
   logic             fifo_empty, fifo_full;
   sif_effect_t      eff;

   assign slot    = bus_addr[5:2];
   assign wr_hit  = bus_wr ? (NSLOT'(1) << slot) : '0;
   assign cmd_wr  = wr_hit[SL_CMD];
   assign push    = wr_hit[SL_FIFO];
   assign pop_req = bus_rd && !bus_wr && (slot == SL_FIFO);
   assign pop_ok  = pop_req && !fifo_empty;

   // write-side shadows
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         len_lo  <= '0;
         len_hi  <= '0;
         tgt_sel <= '0;
      end else begin
         if (wr_hit[SL_LEN_LO]) len_lo  <= bus_wdata;
         if (wr_hit[SL_LEN_HI]) len_hi  <= bus_wdata;
         if (wr_hit[SL_STAT])   tgt_sel <= bus_wdata;
      end
   end
   assign xfer_len = {len_hi, len_lo};

   assign pres8  = 8'(tgt_present);
   assign tgt_ok = pres8[tgt_sel[2:0]];

   sif_cmd_decode i_dec (
      .cmd_wr (cmd_wr),
      .cmd    (bus_wdata),
      .tgt_ok (tgt_ok),
      .eff    (eff)
   );

   sif_byte_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) i_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (eff.flush),
      .push  (push),
      .pop   (pop_ok),
      .din   (bus_wdata),
      .head  (fifo_head),
      .empty (fifo_empty),
      .full  (fifo_full),
      .ovf   (fifo_ovf)
   );

   // read image, one register per slot
   for (genvar s = 0; s < NSLOT; s++) begin : g_img
      localparam logic [3:0] SN    = 4'(s);
      localparam logic [7:0] RST_V = (SN == SL_REV) ? CHIP_REV : 8'h00;
      localparam bit         ECHO  = slot_echoes(s);
      logic [7:0] q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                              q <= RST_V;
         else if (eff.chip_rst)                   q <= RST_V;
         else if (SN == SL_STAT && eff.wr_stat)   q <= eff.stat;
         else if (SN == SL_RSN  && eff.wr_rsn)    q <= eff.rsn;
         else if (SN == SL_STEP && eff.wr_step)   q <= eff.step;
         else if (SN == SL_FIFO && pop_ok)        q <= fifo_head;
         else if (ECHO && wr_hit[s])              q <= bus_wdata;
      end
      assign img[s] = q;
   end

   assign bus_rdata = (slot == SL_FIFO && !fifo_empty) ? fifo_head : img[slot];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 irq <= 1'b0;
      else if (eff.fire || pop_ok) irq <= 1'b1;
      else if (irq_clr)           irq <= 1'b0;
   end

   // R3
   pop_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pop_ok |=> irq);

   // R13
   irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !irq_clr) |=> irq);

   // R9
   sel_absent_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr && (bus_wdata[6:0] == OP_SEL || bus_wdata[6:0] == OP_SELSTP) && !tgt_ok)
      |=> (img[SL_STAT] == 8'h80 && img[SL_RSN] == 8'h20 && irq));

   // R7
   flush_rsn_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr && bus_wdata[6:0] == OP_FLUSH) |=> (img[SL_RSN] == 8'h08 && fifo_empty && !fifo_ovf));

   // R14
   wr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_rd && slot == SL_FIFO && !fifo_full) |=> !fifo_empty);

endmodule

// File: tb/test_sif_reg_front.sv
module test_sif_reg_front;
   localparam int DEPTH = 16;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [5:0] bus_addr = '0;
   logic       bus_wr = 1'b0, bus_rd = 1'b0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic [4:0] tgt_present = 5'b00101;
   logic       irq_clr = 1'b0;
   logic       irq, fifo_ovf;
   logic [15:0] xfer_len;

   int n_chk = 0;
   int n_err = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;   // 125 MHz

   sif_reg_front #(.FIFO_DEPTH(DEPTH), .NUM_TGT(5), .CHIP_REV(8'h04)) i_sif_reg_front (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tgt_present(tgt_present),
      .irq_clr(irq_clr), .irq(irq), .fifo_ovf(fifo_ovf), .xfer_len(xfer_len)
   );

   task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wr(input int s, input logic [7:0] v);
      @(negedge clk);
      bus_addr = 6'(s << 2); bus_wdata = v; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input int s, output logic [7:0] v);
      @(negedge clk);
      bus_addr = 6'(s << 2); bus_rd = 1'b1;
      #1 v = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic clr_irq();
      @(negedge clk); irq_clr = 1'b1;
      @(negedge clk); irq_clr = 1'b0;
   endtask

   task automatic expect_regs(input string tag, input logic [7:0] st, input logic [7:0] rs, input logic [7:0] sp);
      logic [7:0] v;
      rd(4, v); check({tag, " status"}, 16'(v), 16'(st));
      rd(5, v); check({tag, " reason"}, 16'(v), 16'(rs));
      rd(6, v); check({tag, " step"},   16'(v), 16'(sp));
   endtask

   task automatic t_reset();
      logic [7:0] v;
      for (int s = 0; s < 16; s++) begin
         if (s == 2) continue;
         rd(s, v);
         check($sformatf("R2 slot %0d", s), 16'(v), (s == 14) ? 16'h04 : 16'h00);
      end
      check("R2 irq", 16'(irq), 16'h0);
      check("R2 ovf", 16'(fifo_ovf), 16'h0);
   endtask

   task automatic t_map();
      logic [7:0] v;
      bit echo;
      for (int s = 0; s < 16; s++) begin
         if (s == 2 || s == 3) continue;
         wr(s, 8'hA0 | 8'(s));
      end
      for (int s = 0; s < 16; s++) begin
         if (s == 2 || s == 3) continue;
         echo = (s == 0 || s == 1 || s == 8 || s >= 11);
         rd(s, v);
         check($sformatf("R1 slot %0d", s), 16'(v), echo ? 16'(8'hA0 | 8'(s)) : 16'h00);
      end
      check("R1 xfer_len", xfer_len, 16'hA1A0);
      @(negedge clk);
      bus_addr = 6'h23; bus_wdata = 8'h5C; bus_wr = 1'b1;   // slot 8, low bits set
      @(negedge clk); bus_wr = 1'b0;
      rd(8, v); check("R1 low addr bits ignored", 16'(v), 16'h5C);
      check("R12 no irq from plain writes", 16'(irq), 16'h0);
      wr(3, 8'h02);
      rd(0, v);  check("R8 slot 0 cleared", 16'(v), 16'h00);
      rd(3, v);  check("R8 slot 3 cleared", 16'(v), 16'h00);
      rd(14, v); check("R8 revision restored", 16'(v), 16'h04);
   endtask

   task automatic t_fifo();
      logic [7:0] v;
      wr(2, 8'h11); wr(2, 8'h22); wr(2, 8'h33);
      rd(2, v); check("R3 first byte", 16'(v), 16'h11);
      check("R3 irq on pop", 16'(irq), 16'h1);
      clr_irq();
      check("R13 cleared", 16'(irq), 16'h0);
      rd(2, v); check("R3 second byte", 16'(v), 16'h22);
      rd(2, v); check("R3 third byte", 16'(v), 16'h33);
      clr_irq();
      rd(2, v); check("R4 empty returns last", 16'(v), 16'h33);
      check("R4 no irq on empty read", 16'(irq), 16'h0);
      wr(2, 8'h44);
      rd(2, v); check("R5 byte after drain", 16'(v), 16'h44);
      clr_irq();
   endtask

   task automatic t_full();
      logic [7:0] v;
      for (int i = 1; i <= DEPTH + 1; i++) wr(2, 8'(i));
      check("R6 overflow flag", 16'(fifo_ovf), 16'h1);
      for (int i = 1; i <= DEPTH; i++) begin
         rd(2, v); check($sformatf("R6 order %0d", i), 16'(v), 16'(i));
      end
      check("R6 overflow sticky", 16'(fifo_ovf), 16'h1);
      clr_irq();
      wr(2, 8'h77); wr(2, 8'h88);
      wr(3, 8'h01);
      check("R7 overflow cleared", 16'(fifo_ovf), 16'h0);
      check("R7 no irq", 16'(irq), 16'h0);
      rd(5, v); check("R7 reason", 16'(v), 16'h08);
      rd(6, v); check("R7 step", 16'(v), 16'h00);
      rd(2, v); check("R7 fifo emptied", 16'(v), 16'(DEPTH));
      check("R7 empty read no irq", 16'(irq), 16'h0);
   endtask

   task automatic t_chip_keep();
      logic [7:0] v;
      wr(2, 8'h5A);
      wr(3, 8'h02);
      rd(5, v); check("R8 reason cleared", 16'(v), 16'h00);
      check("R8 irq kept low", 16'(irq), 16'h0);
      rd(2, v); check("R8 fifo kept", 16'(v), 16'h5A);
      clr_irq();
   endtask

   task automatic t_sel_fail();
      logic [7:0] v;
      wr(4, 8'h01);
      wr(2, 8'h61);
      wr(3, 8'h42);
      check("R9 irq absent", 16'(irq), 16'h1);
      expect_regs("R9 absent", 8'h80, 8'h20, 8'h00);
      rd(2, v); check("R9 fifo emptied", 16'(v), 16'h5A);
      clr_irq();
      wr(4, 8'h06);
      wr(3, 8'hC3);
      check("R9 irq range", 16'(irq), 16'h1);
      expect_regs("R9 range", 8'h80, 8'h20, 8'h00);
      clr_irq();
   endtask

   task automatic t_sel_ok();
      wr(4, 8'h02);
      wr(3, 8'h43);
      check("R10 irq", 16'(irq), 16'h1);
      expect_regs("R10", 8'h91, 8'h18, 8'h04);
   endtask

   task automatic t_xfer();
      logic [7:0] v;
      clr_irq();
      wr(3, 8'h10);
      check("R11 pio irq", 16'(irq), 16'h1);
      expect_regs("R11 pio", 8'h91, 8'h18, 8'h04);
      rd(3, v); check("R11 cmd echo", 16'(v), 16'h10);
      clr_irq();
      wr(3, 8'h90);
      check("R11 dma irq", 16'(irq), 16'h1);
      expect_regs("R11 dma", 8'h93, 8'h10, 8'h00);
   endtask

   task automatic t_misc();
      logic [7:0] v;
      logic [7:0] ops [4] = '{8'h00, 8'h03, 8'h1A, 8'h55};
      clr_irq();
      wr(3, 8'h12);
      check("R12 msg irq", 16'(irq), 16'h1);
      expect_regs("R12 msg", 8'h93, 8'h20, 8'h00);
      clr_irq();
      for (int k = 0; k < 4; k++) begin
         wr(3, ops[k]);
         check($sformatf("R12 op %h no irq", ops[k]), 16'(irq), 16'h0);
         expect_regs("R12 inert", 8'h93, 8'h20, 8'h00);
         rd(3, v); check("R12 cmd echo", 16'(v), 16'(ops[k]));
      end
   endtask

   task automatic t_irq();
      logic [7:0] v;
      wr(2, 8'h3C);
      @(negedge clk);
      bus_addr = 6'(2 << 2); bus_rd = 1'b1; irq_clr = 1'b1;
      #1 v = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0; irq_clr = 1'b0;
      check("R13 pop byte", 16'(v), 16'h3C);
      check("R13 set wins over clear", 16'(irq), 16'h1);
      repeat (3) @(negedge clk);
      check("R13 level held", 16'(irq), 16'h1);
      clr_irq();
      check("R13 clear", 16'(irq), 16'h0);
   endtask

   task automatic t_both();
      logic [7:0] v;
      wr(2, 8'h71);
      @(negedge clk);
      bus_addr = 6'(2 << 2); bus_wdata = 8'h72; bus_wr = 1'b1; bus_rd = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0; bus_rd = 1'b0;
      rd(2, v); check("R14 old byte kept", 16'(v), 16'h71);
      rd(2, v); check("R14 write landed", 16'(v), 16'h72);
      rd(2, v); check("R14 then empty", 16'(v), 16'h72);
      clr_irq();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_map();
      t_fifo();
      t_full();
      t_chip_keep();
      t_sel_fail();
      t_sel_ok();
      t_xfer();
      t_misc();
      t_irq();
      t_both();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
      $finish;
   end

   initial begin
      #(8 * 100000);
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
         $finish;
      end
   end

endmodule